// File: doc/BRIEF.md
# Integrate-Convert-Dump Sequencer for a Charge-Pump Time-to-Digital Converter

This block sequences a time-to-digital converter whose capacitor array does two jobs: it integrates charge from a phase-detector charge pump, and it serves as the feedback DAC of a successive-approximation ADC. There is no separate track-and-hold step. The block follows an external integration-window input. While the window is high and the sequencer is idle, it enables the charge pump. When the window falls, it resolves the held voltage with a binary search, one trial bit per clock. The comparator answers each trial. When the search ends, the sequencer discharges the array for one clock and presents the code with a one-cycle strobe.

A rising window edge that arrives while a conversion or discharge is still running is reported on an overrun pulse. That edge does not disturb the result in progress.

Top module: `tdc_sar_seq`

## Requirements
- R1: `integ_en_o` is high exactly when `integ_i` is high and the sequencer is idle. It stays low during all conversion and discharge cycles, even if `integ_i` is high.
- R2: A conversion starts on the first clock edge that samples `integ_i` low after it was high while idle. The first trial presented on `dac_o` in the following cycle is mid-scale, binary 1000_0000.
- R3: Trial bits are resolved from MSB to LSB, one per clock, over exactly 8 cycles. A trial bit is kept when `cmp_i` is 1, meaning the DAC level is below the held level, and cleared otherwise. Each new trial adds the next lower bit to the bits already kept.
- R4: For a comparator that reports `dac < V` with integer held level V, the final code is 0 for V = 0, V-1 for 1 <= V <= 256, and 255 above that.
- R5: `dump_o` is high for exactly one cycle. That cycle is the 9th cycle after the conversion-starting edge, directly after the last decision.
- R6: `valid_o` pulses in the same single cycle as `dump_o`. `code_o` changes only at that point and holds the result until the next conversion ends.
- R7: A rising edge of `integ_i` sampled while converting or discharging gives a one-cycle `overrun_o` pulse in the next cycle, and the result of the conversion is unchanged. A rising edge sampled while idle gives no pulse.
- R8: A falling edge of `integ_i` sampled while converting or discharging is ignored. It starts no second conversion and produces no extra strobe.
- R9: While the active-low asynchronous reset `rst_n` is asserted, all outputs are zero when `integ_i` is low.
- R10: `dac_o` is zero in every cycle outside the 8 conversion cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered carrier clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| integ_i | input | 1 | Integration window from the programmable divider |
| cmp_i | input | 1 | Comparator: 1 when the DAC level is below the held level |
| integ_en_o | output | 1 | Enable for the phase-detector / charge-pump path |
| dac_o | output | 8 | Trial bits to the capacitor array |
| dump_o | output | 1 | One-cycle discharge of the array |
| code_o | output | 8 | Converted code |
| valid_o | output | 1 | One-cycle strobe marking a new code |
| overrun_o | output | 1 | Window rose before the previous cycle finished |

## Verification
The main sweep integrates for every window length from 1 to 260 clocks. A bench-side charge model counts enabled cycles, so every reachable code is covered, and the clamp at full scale is separated from the plain V-1 result. At each step, the expected trial pattern is rebuilt from the bench's own comparator decisions. This separates a wrong bit order or a wrong keep/clear rule from a mere final-code error.

Further runs raise the window at three points: mid-conversion (and lower it again), in the discharge cycle, and one cycle after the discharge. These runs tell apart a correct overrun flag, a spurious flag in the idle state, a falling edge that wrongly restarts the search, and charge leaking into the array while busy.

// File: rtl/tdc_sar_pkg.sv
package tdc_sar_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_DUMP = 2'd2
  } seq_state_e;

  // One successive-approximation step: resolve the bit under the pointer,
  // then raise the next lower bit as the new trial.
  function automatic logic [7:0] sar_step8(input logic [7:0] trial,
                                           input logic [7:0] ptr,
                                           input logic       keep);
    logic [7:0] t;
    t = keep ? trial : (trial & ~ptr);
    return t | (ptr >> 1);
  endfunction

endpackage

// File: rtl/tdc_edge_det.sv
module tdc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/tdc_seq_fsm.sv
module tdc_seq_fsm
  import tdc_sar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic       last_i,
  output seq_state_e state_o,
  output logic       start_o
);
  seq_state_e state_q, state_d;

  assign start_o = (state_q == SEQ_IDLE) && fall_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (fall_i) state_d = SEQ_CONV;
      SEQ_CONV: if (last_i) state_d = SEQ_DUMP;
      SEQ_DUMP: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/tdc_sar_reg.sv
module tdc_sar_reg
  import tdc_sar_pkg::*;
#(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                conv_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] trial_o,
  output logic                last_o,
  output logic [RES_BITS-1:0] code_o
);
  localparam logic [RES_BITS-1:0] MID_SCALE = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] trial_q, ptr_q, code_q;
  logic [RES_BITS-1:0] trial_next;

  always_comb begin
    logic [RES_BITS-1:0] kept;
    kept       = cmp_i ? trial_q : (trial_q & ~ptr_q);
    trial_next = kept | (ptr_q >> 1);
  end

  assign last_o = conv_i && ptr_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      ptr_q   <= '0;
      code_q  <= '0;
    end else if (start_i) begin
      trial_q <= MID_SCALE;
      ptr_q   <= MID_SCALE;
    end else if (conv_i) begin
      trial_q <= trial_next;
      ptr_q   <= ptr_q >> 1;
      if (ptr_q[0]) code_q <= trial_next;
    end
  end

  assign trial_o = trial_q;
  assign code_o  = code_q;
endmodule

// File: rtl/tdc_sar_seq.sv
module tdc_sar_seq
  import tdc_sar_pkg::*;
#(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                integ_i,
  input  logic                cmp_i,
  output logic                integ_en_o,
  output logic [RES_BITS-1:0] dac_o,
  output logic                dump_o,
  output logic [RES_BITS-1:0] code_o,
  output logic                valid_o,
  output logic                overrun_o
);
  logic       rise_w, fall_w, start_w, done_w, idle_w, conv_w;
  logic       overrun_q;
  seq_state_e state_w;
  logic [RES_BITS-1:0] trial_w;

  tdc_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(integ_i),
    .rise_o(rise_w), .fall_o(fall_w)
  );

  tdc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fall_i(fall_w), .last_i(done_w),
    .state_o(state_w), .start_o(start_w)
  );

  tdc_sar_reg #(.RES_BITS(RES_BITS)) u_sar (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .conv_i(conv_w),
    .cmp_i(cmp_i), .trial_o(trial_w), .last_o(done_w), .code_o(code_o)
  );

  assign idle_w = (state_w == SEQ_IDLE);
  assign conv_w = (state_w == SEQ_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun_q <= 1'b0;
    else        overrun_q <= rise_w && !idle_w;
  end

  assign integ_en_o = integ_i && idle_w;
  assign dac_o      = conv_w ? trial_w : '0;
  assign dump_o     = (state_w == SEQ_DUMP);
  assign valid_o    = (state_w == SEQ_DUMP);
  assign overrun_o  = overrun_q;
endmodule

// File: rtl/tdc_sar_seq_chk.sv
module tdc_sar_seq_chk #(
  parameter int RES_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                integ_en_o,
  input logic [RES_BITS-1:0] dac_o,
  input logic                dump_o,
  input logic [RES_BITS-1:0] code_o,
  input logic                valid_o,
  input logic                overrun_o,
  input logic                rise_w,
  input logic                start_w,
  input logic                done_w,
  input logic                idle_w,
  input logic                conv_w
);
  localparam logic [RES_BITS-1:0] MID_SCALE = {1'b1, {(RES_BITS-1){1'b0}}};
  localparam int CW = $clog2(RES_BITS + 1);

  logic [CW-1:0] conv_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      conv_cnt <= '0;
    else if (!conv_w) conv_cnt <= '0;
    else             conv_cnt <= conv_cnt + 1'b1;
  end

  assert_integ_off_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_w |-> !integ_en_o);
  assert_start_midscale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> dac_o == MID_SCALE);
  assert_step_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |-> conv_cnt == CW'(RES_BITS - 1));
  assert_done_to_dump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> dump_o);
  assert_dump_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dump_o |=> !dump_o);
  assert_valid_with_dump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> dump_o);
  assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |=> $stable(code_o));
  assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w && !idle_w) |=> overrun_o);
  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(rise_w));
  assert_dac_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_w |-> dac_o == '0);
endmodule

bind tdc_sar_seq tdc_sar_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .integ_en_o(integ_en_o), .dac_o(dac_o),
  .dump_o(dump_o), .code_o(code_o), .valid_o(valid_o), .overrun_o(overrun_o),
  .rise_w(rise_w), .start_w(start_w), .done_w(done_w), .idle_w(idle_w),
  .conv_w(conv_w)
);

// File: tb/tdc_sar_seq_tb.sv
module tdc_sar_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       integ_i = 1'b0;
  logic       cmp_i = 1'b0;
  logic       integ_en_o, dump_o, valid_o, overrun_o;
  logic [7:0] dac_o, code_o;

  int checks = 0;
  int errors = 0;
  int held = 0;

  always #5 clk = ~clk;

  tdc_sar_seq u_dut (
    .clk(clk), .rst_n(rst_n), .integ_i(integ_i), .cmp_i(cmp_i),
    .integ_en_o(integ_en_o), .dac_o(dac_o), .dump_o(dump_o),
    .code_o(code_o), .valid_o(valid_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expect_code(input int v);
    if (v <= 0) return 0;
    if (v - 1 > 255) return 255;
    return v - 1;
  endfunction

  // n clocks of integration, then a conversion; optional window rise/fall
  // at given conversion steps (0 = none).
  task automatic run_conv(input int n, input int raise_at, input int lower_at);
    int v;
    int acc;
    int expd;
    integ_i = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (integ_en_o) held++;
      chk(integ_en_o == 1'b1, "R1 enable while idle", integ_en_o, 1);
      chk(overrun_o == 1'b0, "R7 no overrun in idle", overrun_o, 0);
    end
    integ_i = 1'b0;
    v = held;
    acc = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (integ_en_o) held++;
      if (k <= 9) chk(integ_en_o == 1'b0, "R1 enable off while busy", integ_en_o, 0);
      if (k <= 8) begin
        expd = acc | (1 << (8 - k));
        if (k == 1) chk(dac_o == 8'h80, "R2 mid-scale first trial", dac_o, 8'h80);
        chk(dac_o == expd[7:0], "R3 trial pattern", dac_o, expd);
        if (expd < v) acc = expd;
      end else begin
        chk(dac_o == 8'h00, "R10 dac quiet", dac_o, 0);
      end
      chk(dump_o == (k == 9), "R5 dump timing", dump_o, k == 9);
      chk(valid_o == (k == 9), "R6 valid with dump", valid_o, k == 9);
      if (k == 9) chk(code_o == expect_code(v), "R4 final code", code_o, expect_code(v));
      if (k > 9) chk(code_o == expect_code(v), "R6 code holds", code_o, expect_code(v));
      chk(overrun_o == (raise_at >= 1 && raise_at <= 9 && k == raise_at + 1),
          "R7 overrun pulse", overrun_o,
          raise_at >= 1 && raise_at <= 9 && k == raise_at + 1);
      if (k == raise_at) integ_i = 1'b1;
      if (k == lower_at) integ_i = 1'b0;
      cmp_i = (int'(dac_o) < held);
      if (dump_o) held = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(integ_en_o == 0, "R9 reset enable", integ_en_o, 0);
    chk(dac_o == 0, "R9 reset dac", dac_o, 0);
    chk(dump_o == 0, "R9 reset dump", dump_o, 0);
    chk(valid_o == 0, "R9 reset valid", valid_o, 0);
    chk(code_o == 0, "R9 reset code", code_o, 0);
    chk(overrun_o == 0, "R9 reset overrun", overrun_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: sweep all reachable held levels including the clamp.
    for (int n = 1; n <= 260; n++) run_conv(n, 0, 0);
    // R7 and R8: rise mid-conversion then fall while still busy.
    run_conv(40, 3, 5);
    run_conv(200, 0, 0);
    // R7: rise during the discharge cycle; window stays high afterwards.
    run_conv(100, 9, 0);
    run_conv(20, 0, 0);
    // R7: rise right after discharge, idle, must not flag.
    run_conv(77, 10, 0);
    run_conv(5, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule